// File: doc/BRIEF.md
# Motion-Adaptive Macroblock QP Selector

This block picks the quantization parameter (QP) for each macroblock of a block-based video encoder. The encoder supplies a programmable intra base QP, a frame type for the current frame (intra, predicted or bidirectional), and one motion class per macroblock from an upstream motion analyser. The block adds an offset to the base that depends on both the frame type and the motion class, saturates the sum to the legal QP range, and returns one QP per macroblock through a valid/ready pair.

Intra frames keep the finest quantization. Inside an intra frame, still areas may be given a coarser QP. Predicted frames coarsen in step with motion speed, because fast content hides loss. Bidirectional frames, which are never referenced, always sit above a predicted frame for the same motion class. The offsets and the base sit in shadow configuration registers. Writes land in the shadow copy, and the whole set, together with the frame type, is copied into the working set on a frame-start pulse. Every macroblock of a frame is therefore quantized under one consistent configuration.

Top module: `mb_qp_select`

## Requirements
- R1: After reset `qp_valid` is low and `mb_ready` is high. The working configuration is base 26, still-intra offset 2, fast offset 3, bidirectional offset 2 and still-predicted offset 2, and the frame type is intra.
- R2: Frame type code 00 is intra. A still macroblock (motion code 00) gets base plus the still-intra offset. Slow (01) and fast (10, 11) macroblocks get the base unchanged.
- R3: Frame type code 01 is predicted. A still macroblock gets base plus the still-predicted offset, a slow one gets base plus 2, and a fast one (code 10) gets base plus the fast offset.
- R4: Frame type codes 10 and 11 are bidirectional. The result is the predicted-frame value for the same motion class plus the bidirectional offset, and that offset is never 0.
- R5: Every output QP is the unsaturated sum limited to at most 51.
- R6: Motion code 11 is handled exactly as fast motion (code 10) in every frame type.
- R7: A write sets `cfg_we` with `cfg_sel` naming a register: 0 base, 1 still-intra offset, 2 fast offset, 3 bidirectional offset, 4 still-predicted offset. A write is ignored if the data is out of range for that register: base above 51, fast offset other than 3 or 4, bidirectional offset of 0, any offset above 15. Writes with selects 5 to 7 are also ignored.
- R8: The base, the offsets and the frame type are taken from the shadow registers on a `frame_start` cycle and then stay fixed until the next one. A macroblock accepted in the `frame_start` cycle already uses the new set. A write made in that same cycle belongs to the following frame.
- R9: A macroblock accepted on a clock edge (`mb_valid` and `mb_ready` high) appears on `qp_out` with `qp_valid` after that edge. While `qp_ready` is low the output holds its value. `mb_ready` is high exactly when `qp_ready` is high or `qp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select for the write |
| cfg_data | input | 6 | Write data |
| frame_start | input | 1 | One-cycle pulse at the start of a frame |
| frame_type | input | 2 | Type of the frame that starts: 00 intra, 01 predicted, 1x bidirectional |
| mb_valid | input | 1 | Macroblock motion class is valid |
| mb_ready | output | 1 | Block can accept a macroblock |
| mb_motion | input | 2 | Motion class: 00 still, 01 slow, 10 fast, 11 fast |
| qp_valid | output | 1 | Output QP is valid |
| qp_ready | input | 1 | Consumer accepts the QP |
| qp_out | output | 6 | Selected QP |

## Verification
Three things can fall in one cycle: a frame start, a macroblock acceptance and a configuration write. The block must then use the freshly latched set for the macroblock and keep the write for the frame after. The bench provokes this both in directed cycles that raise all three strobes together and in a long random phase where the strobes and backpressure land at random. A behavioural model that applies the copy-then-compute-then-write order is compared with the ports on every clock.

// File: rtl/mbqp_pkg.sv
package mbqp_pkg;

   typedef enum logic [1:0] {
      FR_INTRA = 2'b00,
      FR_PRED  = 2'b01,
      FR_BI    = 2'b10,
      FR_BI_X  = 2'b11
   } frame_kind_e;

   typedef enum logic [1:0] {
      MV_STILL = 2'b00,
      MV_SLOW  = 2'b01,
      MV_FAST  = 2'b10,
      MV_RSV   = 2'b11
   } motion_kind_e;

   // register select codes; offsets use select = slot + 1
   localparam logic [2:0] SEL_BASE = 3'd0;

   // offset slot numbering
   localparam int SLOT_STILL_I = 0;
   localparam int SLOT_FAST    = 1;
   localparam int SLOT_BI      = 2;
   localparam int SLOT_STILL_P = 3;
   localparam int N_SLOTS      = 4;

endpackage

// File: rtl/mbqp_cfg_regs.sv
module mbqp_cfg_regs
   import mbqp_pkg::*;
#(
   parameter int QP_W        = 6,
   parameter int OFF_W       = 4,
   parameter int QP_MAX      = 51,
   parameter int BASE_RST    = 26,
   parameter int STILL_I_RST = 2,
   parameter int FAST_RST    = 3,
   parameter int BI_RST      = 2,
   parameter int STILL_P_RST = 2,
   parameter int FAST_MIN    = 3,
   parameter int FAST_MAX    = 4,
   parameter int BI_MIN      = 1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_we,
   input  logic [2:0]                    cfg_sel,
   input  logic [QP_W-1:0]               cfg_data,
   input  logic                          frame_start,
   input  logic [1:0]                    frame_type,
   output logic [QP_W-1:0]               eff_base,
   output logic [N_SLOTS-1:0][OFF_W-1:0] eff_off,
   output frame_kind_e                   eff_frame,
   output frame_kind_e                   act_frame
);

   localparam int OFF_TOP = (1 << OFF_W) - 1;

   function automatic int slot_lo(input int s);
      case (s)
         SLOT_FAST: return FAST_MIN;
         SLOT_BI:   return BI_MIN;
         default:   return 0;
      endcase
   endfunction

   function automatic int slot_hi(input int s);
      if (s == SLOT_FAST) return FAST_MAX;
      return OFF_TOP;
   endfunction

   function automatic int slot_rst(input int s);
      case (s)
         SLOT_STILL_I: return STILL_I_RST;
         SLOT_FAST:    return FAST_RST;
         SLOT_BI:      return BI_RST;
         default:      return STILL_P_RST;
      endcase
   endfunction

   logic [QP_W-1:0] shd_base, act_base;
   int              wr_val;

   assign wr_val = int'(cfg_data);

   // base register: shadow plus working copy
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shd_base <= QP_W'(BASE_RST);
      end else if (cfg_we && cfg_sel == SEL_BASE && wr_val <= QP_MAX) begin
         shd_base <= cfg_data;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_base  <= QP_W'(BASE_RST);
         act_frame <= FR_INTRA;
      end else if (frame_start) begin
         act_base  <= shd_base;
         act_frame <= frame_kind_e'(frame_type);
      end
   end

   assign eff_base  = frame_start ? shd_base : act_base;
   assign eff_frame = frame_start ? frame_kind_e'(frame_type) : act_frame;

   // one shadow/working pair per offset slot, each with its own legal window
   for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
      localparam int         LO  = slot_lo(s);
      localparam int         HI  = slot_hi(s);
      localparam logic [2:0] SEL = 3'(s + 1);

      logic [OFF_W-1:0] shd_q, act_q;
      logic             wr_hit;

      assign wr_hit = cfg_we && (cfg_sel == SEL) && (wr_val >= LO) && (wr_val <= HI);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            shd_q <= OFF_W'(slot_rst(s));
         end else if (wr_hit) begin
            shd_q <= cfg_data[OFF_W-1:0];
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            act_q <= OFF_W'(slot_rst(s));
         end else if (frame_start) begin
            act_q <= shd_q;
         end
      end

      assign eff_off[s] = frame_start ? shd_q : act_q;
   end

endmodule

// File: rtl/mbqp_offset_calc.sv
module mbqp_offset_calc
   import mbqp_pkg::*;
#(
   parameter int QP_W        = 6,
   parameter int OFF_W       = 4,
   parameter int QP_MAX      = 51,
   parameter int SLOW_P_OFF  = 2,
   parameter bit RSV_AS_FAST = 1'b1
) (
   input  logic [QP_W-1:0]               base,
   input  logic [N_SLOTS-1:0][OFF_W-1:0] offs,
   input  frame_kind_e                   frame,
   input  logic [1:0]                    motion,
   output logic [QP_W-1:0]               qp
);

   localparam int SUM_W   = QP_W + 2;
   localparam int N_CLASS = 4;

   logic [SUM_W-1:0] intra_add [N_CLASS];
   logic [SUM_W-1:0] pred_add  [N_CLASS];
   logic [SUM_W-1:0] bi_add;
   logic [SUM_W-1:0] sel_add;
   logic [SUM_W-1:0] raw;

   // per-class offset table; the reserved class follows the chosen variant
   for (genvar c = 0; c < N_CLASS; c++) begin : g_class
      if (c == int'(MV_STILL)) begin : g_still
         assign intra_add[c] = SUM_W'(offs[SLOT_STILL_I]);
         assign pred_add[c]  = SUM_W'(offs[SLOT_STILL_P]);
      end else if (c == int'(MV_SLOW) || (c == int'(MV_RSV) && !RSV_AS_FAST)) begin : g_slow
         assign intra_add[c] = '0;
         assign pred_add[c]  = SUM_W'(SLOW_P_OFF);
      end else begin : g_fast
         assign intra_add[c] = '0;
         assign pred_add[c]  = SUM_W'(offs[SLOT_FAST]);
      end
   end

   assign bi_add = SUM_W'(offs[SLOT_BI]);

   always_comb begin
      unique case (frame)
         FR_INTRA: sel_add = intra_add[motion];
         FR_PRED:  sel_add = pred_add[motion];
         default:  sel_add = pred_add[motion] + bi_add;
      endcase
      raw = SUM_W'(base) + sel_add;
      if (raw > SUM_W'(QP_MAX)) begin
         qp = QP_W'(QP_MAX);
      end else begin
         qp = raw[QP_W-1:0];
      end
   end

endmodule

// File: rtl/mbqp_out_stage.sv
module mbqp_out_stage #(
   parameter int W = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   output logic         in_ready,
   input  logic [W-1:0] in_data,
   output logic         out_valid,
   input  logic         out_ready,
   output logic [W-1:0] out_data
);

   logic take;

   assign in_ready = out_ready || !out_valid;
   assign take     = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
      end else if (take) begin
         out_valid <= 1'b1;
      end else if (out_ready) begin
         out_valid <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_data <= '0;
      end else if (take) begin
         out_data <= in_data;
      end
   end

endmodule

// File: rtl/mb_qp_select.sv
module mb_qp_select
   import mbqp_pkg::*;
#(
   parameter int QP_W        = 6,
   parameter int OFF_W       = 4,
   parameter int QP_MAX      = 51,
   parameter int BASE_RST    = 26,
   parameter int STILL_I_RST = 2,
   parameter int FAST_RST    = 3,
   parameter int BI_RST      = 2,
   parameter int STILL_P_RST = 2,
   parameter int SLOW_P_OFF  = 2,
   parameter int FAST_MIN    = 3,
   parameter int FAST_MAX    = 4,
   parameter bit RSV_AS_FAST = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cfg_we,
   input  logic [2:0]      cfg_sel,
   input  logic [QP_W-1:0] cfg_data,
   input  logic            frame_start,
   input  logic [1:0]      frame_type,
   input  logic            mb_valid,
   output logic            mb_ready,
   input  logic [1:0]      mb_motion,
   output logic            qp_valid,
   input  logic            qp_ready,
   output logic [QP_W-1:0] qp_out
);

   localparam int OFF_TOP = (1 << OFF_W) - 1;
   localparam int BI_MIN  = 1;

   initial begin
      if (QP_MAX >= (1 << QP_W)) $fatal(1, "QP_MAX does not fit QP_W");
      if (OFF_W > QP_W) $fatal(1, "OFF_W must not exceed QP_W");
      if (FAST_MIN > FAST_MAX || FAST_MAX > OFF_TOP) $fatal(1, "fast offset window illegal");
      if (FAST_RST < FAST_MIN || FAST_RST > FAST_MAX) $fatal(1, "fast offset reset illegal");
      if (BI_RST < BI_MIN || BI_RST > OFF_TOP) $fatal(1, "bidirectional offset reset illegal");
      if (BASE_RST > QP_MAX) $fatal(1, "base reset above QP_MAX");
      if (STILL_I_RST > OFF_TOP || STILL_P_RST > OFF_TOP) $fatal(1, "still offset reset too wide");
   end

   logic [QP_W-1:0]               eff_base;
   logic [N_SLOTS-1:0][OFF_W-1:0] eff_off;
   logic [OFF_W-1:0]              eff_fast;
   frame_kind_e                   eff_frame;
   frame_kind_e                   act_frame;
   logic [QP_W-1:0]               qp_next;

   assign eff_fast = eff_off[SLOT_FAST];

   mbqp_cfg_regs #(
      .QP_W        (QP_W),
      .OFF_W       (OFF_W),
      .QP_MAX      (QP_MAX),
      .BASE_RST    (BASE_RST),
      .STILL_I_RST (STILL_I_RST),
      .FAST_RST    (FAST_RST),
      .BI_RST      (BI_RST),
      .STILL_P_RST (STILL_P_RST),
      .FAST_MIN    (FAST_MIN),
      .FAST_MAX    (FAST_MAX),
      .BI_MIN      (BI_MIN)
   ) u_cfg (
      .clk         (clk),
      .rst_n       (rst_n),
      .cfg_we      (cfg_we),
      .cfg_sel     (cfg_sel),
      .cfg_data    (cfg_data),
      .frame_start (frame_start),
      .frame_type  (frame_type),
      .eff_base    (eff_base),
      .eff_off     (eff_off),
      .eff_frame   (eff_frame),
      .act_frame   (act_frame)
   );

   mbqp_offset_calc #(
      .QP_W        (QP_W),
      .OFF_W       (OFF_W),
      .QP_MAX      (QP_MAX),
      .SLOW_P_OFF  (SLOW_P_OFF),
      .RSV_AS_FAST (RSV_AS_FAST)
   ) u_calc (
      .base   (eff_base),
      .offs   (eff_off),
      .frame  (eff_frame),
      .motion (mb_motion),
      .qp     (qp_next)
   );

   mbqp_out_stage #(
      .W (QP_W)
   ) u_out (
      .clk       (clk),
      .rst_n     (rst_n),
      .in_valid  (mb_valid),
      .in_ready  (mb_ready),
      .in_data   (qp_next),
      .out_valid (qp_valid),
      .out_ready (qp_ready),
      .out_data  (qp_out)
   );

endmodule

// File: rtl/mb_qp_select_chk.sv
module mb_qp_select_chk #(
   parameter int QP_W     = 6,
   parameter int OFF_W    = 4,
   parameter int QP_MAX   = 51,
   parameter int FAST_MIN = 3,
   parameter int FAST_MAX = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic             frame_start,
   input logic             mb_valid,
   input logic             mb_ready,
   input logic             qp_valid,
   input logic             qp_ready,
   input logic [QP_W-1:0]  qp_out,
   input logic [OFF_W-1:0] eff_fast,
   input logic [1:0]       act_frame
);

   // R9
   hold_under_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (qp_valid && !qp_ready) |=> (qp_valid && $stable(qp_out)));

   // R9
   accept_to_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mb_valid && mb_ready) |=> qp_valid);

   // R5
   qp_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      qp_valid |-> (int'(qp_out) <= QP_MAX));

   // R7
   fast_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(eff_fast) >= FAST_MIN) && (int'(eff_fast) <= FAST_MAX));

   // R8
   frame_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !frame_start |=> $stable(act_frame));

endmodule

bind mb_qp_select mb_qp_select_chk #(
   .QP_W     (QP_W),
   .OFF_W    (OFF_W),
   .QP_MAX   (QP_MAX),
   .FAST_MIN (FAST_MIN),
   .FAST_MAX (FAST_MAX)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .frame_start (frame_start),
   .mb_valid    (mb_valid),
   .mb_ready    (mb_ready),
   .qp_valid    (qp_valid),
   .qp_ready    (qp_ready),
   .qp_out      (qp_out),
   .eff_fast    (eff_fast),
   .act_frame   (act_frame)
);

// File: tb/mb_qp_select_tb_top.sv
`timescale 1ns/1ps
module mb_qp_select_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       cfg_we = 1'b0;
   logic [2:0] cfg_sel = '0;
   logic [5:0] cfg_data = '0;
   logic       frame_start = 1'b0;
   logic [1:0] frame_type = '0;
   logic       mb_valid = 1'b0;
   logic       mb_ready;
   logic [1:0] mb_motion = '0;
   logic       qp_valid;
   logic       qp_ready = 1'b0;
   logic [5:0] qp_out;

   always #4 clk = ~clk;

   mb_qp_select dut_i (
      .clk (clk), .rst_n (rst_n), .cfg_we (cfg_we), .cfg_sel (cfg_sel),
      .cfg_data (cfg_data), .frame_start (frame_start), .frame_type (frame_type),
      .mb_valid (mb_valid), .mb_ready (mb_ready), .mb_motion (mb_motion),
      .qp_valid (qp_valid), .qp_ready (qp_ready), .qp_out (qp_out)
   );

   int    n_checks = 0;
   int    n_errors = 0;
   string phase = "R1";

   // behavioural model state: shadow s_*, working a_*
   int    s_base, s_si, s_f, s_b, s_sp;
   int    a_base, a_si, a_f, a_b, a_sp, a_fr;
   bit    m_vld;
   int    m_qp;
   string m_tag;

   function automatic void model_reset();
      s_base = 26; s_si = 2; s_f = 3; s_b = 2; s_sp = 2;
      a_base = 26; a_si = 2; a_f = 3; a_b = 2; a_sp = 2; a_fr = 0;
      m_vld = 0; m_qp = 0; m_tag = "R1";
   endfunction

   function automatic int pred_off(int mv);
      if (mv == 0) return a_sp;
      if (mv == 1) return 2;
      return a_f;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         model_reset();
      end else begin
         bit in_rdy;
         int raw;
         if (frame_start) begin
            a_base = s_base; a_si = s_si; a_f = s_f; a_b = s_b; a_sp = s_sp;
            a_fr = int'(frame_type);
         end
         in_rdy = qp_ready || !m_vld;
         if (mb_valid && in_rdy) begin
            if (a_fr == 0) begin
               raw = a_base + ((mb_motion == 2'd0) ? a_si : 0);
               m_tag = "R2";
            end else if (a_fr == 1) begin
               raw = a_base + pred_off(int'(mb_motion));
               m_tag = (mb_motion == 2'd3) ? "R6" : "R3";
            end else begin
               raw = a_base + pred_off(int'(mb_motion)) + a_b;
               m_tag = (mb_motion == 2'd3) ? "R6" : "R4";
            end
            if (raw > 51) begin
               raw = 51;
               m_tag = "R5";
            end
            m_qp = raw;
            m_vld = 1;
         end else if (qp_ready) begin
            m_vld = 0;
         end
         if (cfg_we) begin
            case (cfg_sel)
               3'd0: if (cfg_data <= 6'd51) s_base = int'(cfg_data);
               3'd1: if (cfg_data <= 6'd15) s_si = int'(cfg_data);
               3'd2: if (cfg_data == 6'd3 || cfg_data == 6'd4) s_f = int'(cfg_data);
               3'd3: if (cfg_data >= 6'd1 && cfg_data <= 6'd15) s_b = int'(cfg_data);
               3'd4: if (cfg_data <= 6'd15) s_sp = int'(cfg_data);
               default: ;
            endcase
         end
      end
   end

   task automatic check(string tag, int got, int exp, string what);
      n_checks++;
      if (got != exp) begin
         n_errors++;
         $display("FAIL %s (%s) %s: got %0d expected %0d", tag, phase, what, got, exp);
      end
   endtask

   // compare ports with the model, away from the active edge
   task automatic compare();
      check(rst_n ? "R9" : "R1", int'(qp_valid), int'(m_vld), "qp_valid");
      check(rst_n ? "R9" : "R1", int'(mb_ready), int'(qp_ready || !m_vld), "mb_ready");
      if (m_vld) check(m_tag, int'(qp_out), m_qp, "qp_out");
   endtask

   task automatic tick();
      @(negedge clk);
      compare();
      frame_start = 1'b0;
      cfg_we = 1'b0;
   endtask

   task automatic traffic(int n, int pv, int pr);
      for (int i = 0; i < n; i++) begin
         tick();
         mb_valid  = ($urandom_range(99) < pv);
         qp_ready  = ($urandom_range(99) < pr);
         mb_motion = 2'($urandom_range(3));
      end
   endtask

   task automatic new_frame(int ft);
      tick();
      frame_start = 1'b1;
      frame_type  = 2'(ft);
      mb_valid    = 1'b1;
      mb_motion   = 2'($urandom_range(3));
   endtask

   task automatic write(int sel, int data);
      tick();
      cfg_we   = 1'b1;
      cfg_sel  = 3'(sel);
      cfg_data = 6'(data);
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_errors++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      model_reset();
      // R1: reset state and default configuration
      phase = "R1";
      repeat (3) tick();
      rst_n = 1'b1;
      traffic(60, 70, 70);

      // R2 R3 R4 R6: defaults in each frame type, under backpressure
      phase = "R2";  new_frame(0); traffic(120, 80, 60);
      phase = "R3";  new_frame(1); traffic(120, 80, 60);
      phase = "R4";  new_frame(2); traffic(120, 80, 60);
      phase = "R4x"; new_frame(3); traffic(120, 80, 60);

      // R5: push sums past 51; R8: the writes wait for the next frame
      phase = "R5";
      write(0, 50); write(1, 15); write(4, 15); write(3, 15); write(2, 4);
      traffic(60, 80, 80);
      new_frame(0); traffic(80, 80, 80);
      new_frame(1); traffic(80, 80, 80);
      new_frame(2); traffic(80, 80, 80);

      // R7: illegal writes are dropped, legal ones are kept
      phase = "R7";
      write(0, 20); write(1, 1); write(3, 1); write(4, 3); write(2, 3);
      write(2, 7); write(2, 2); write(3, 0); write(0, 60); write(1, 40);
      write(5, 9); write(7, 1);
      new_frame(1); traffic(100, 90, 90);
      new_frame(2); traffic(100, 90, 90);
      new_frame(0); traffic(100, 90, 90);

      // R8: write, frame start and acceptance in one cycle
      phase = "R8";
      for (int k = 0; k < 6; k++) begin
         tick();
         frame_start = 1'b1;
         frame_type  = 2'(k % 4);
         cfg_we      = 1'b1;
         cfg_sel     = 3'(k % 5);
         cfg_data    = 6'(k + 3);
         mb_valid    = 1'b1;
         qp_ready    = 1'b1;
         mb_motion   = 2'(k % 4);
         traffic(20, 90, 50);
      end

      // R9: random mix of everything
      phase = "R9";
      for (int i = 0; i < 4000; i++) begin
         tick();
         mb_valid    = ($urandom_range(99) < 75);
         qp_ready    = ($urandom_range(99) < 65);
         mb_motion   = 2'($urandom_range(3));
         frame_start = ($urandom_range(99) < 3);
         frame_type  = 2'($urandom_range(3));
         cfg_we      = ($urandom_range(99) < 6);
         cfg_sel     = 3'($urandom_range(7));
         cfg_data    = 6'($urandom_range(63));
      end
      tick();
      summary();
      $finish;
   end

endmodule